// File: doc/BRIEF.md
# Serial Management Slave with Optional Preamble Skipping

This block is the device side of a two-wire serial management bus. It runs directly on the management clock, samples the data line on each rising edge and decodes frames made of a run of ones (the preamble), a `01` start marker, a two-bit operation code, a five-bit device address, a five-bit register address, a two-bit turnaround and sixteen data bits sent most significant bit first. A frame for this device either writes one of its registers or makes the block drive the register's contents back over the same line, using a separate output-enable for the shared wire.

The block holds four registers: a control word, a status word whose bits are fixed except for the preamble-skip enable, an extended control word that carries an override bit, and a scratch word. Several devices can share the bus, because each one answers only to the five-bit address on its strap pins. Frames with an unknown operation code or another device's address are ignored. The decoder counts out the rest of such a frame before it looks for the next one. When preamble skipping is enabled, a frame may begin directly with the start marker.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset the output enable is low, the control word reads 0x1000, the status word reads 0x7809 (preamble-skip enable, status bit 6, is 0), and the extended and scratch words read 0x0000.
- R2: With preamble skipping disabled, a frame is acted on only if at least 32 consecutive ones were sampled immediately before its `01` start marker. A frame preceded by only 31 ones neither writes nor drives the line.
- R3: The operation code that follows the start marker selects the access: `10` reads and `01` writes.
- R4: Frames with operation code `00` or `11` produce no drive and change no register. The next frame, sent right after the 64 bits of the ignored one, is served normally.
- R5: The block responds only when the five-bit device address, sent after the operation code and MSB first, equals the `phy_addr` input.
- R6: On a matching read, the enable stays low during the first turnaround bit. The block drives 0 in the second turnaround bit and then the sixteen register bits MSB first, and it releases the line in the bit after the last data bit.
- R7: A matching write stores the sixteen data bits, sent MSB first, into the control word (address 0), the extended word (address 16) or the scratch word (address 17).
- R8: A write to address 1 changes only status bit 6, and only if bit 15 of the extended word is already 1. The other status bits always read back as 0x7809.
- R9: With preamble skipping enabled, a frame that starts with `01` and has no preamble is served.
- R10: Register addresses other than 0, 1, 16 and 17 read as 0x0000, and writes to them change nothing.
- R11: The output and enable change only after a rising clock edge. The line is driven only during the second turnaround bit and the data bits of a matching read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; data sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
If the decoder loses its place in a frame, the ports show it within the same frame. A read then returns shifted or wrong data, or the enable rises one bit early or late. The enable can also stay high past the seventeenth bit, where the bench samples the release. A wrong preamble or skip count makes the next frame go unanswered, or makes a short-preamble frame take effect. Each of these shows up when the next register is read back, one frame (64 to 65 clocks) later. A wrong override or enable state appears in bit 6 of the status read, and it changes whether a frame without a preamble gets an answer.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SFD,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_SKIP
    } mgmt_state_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam int         OP_W  = 2;
    localparam int         TA_W  = 2;
endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              sup_en,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int HDR_W    = OP_W + 2 * ADDR_W;
    localparam int SKIP_LEN = TA_W + DATA_W;
    localparam int MAX_CNT  = (SKIP_LEN > HDR_W) ? SKIP_LEN : HDR_W;
    localparam int CNT_W    = $clog2(MAX_CNT);
    localparam int ONES_W   = $clog2(PRE_LEN + 1);

    typedef struct packed {
        mgmt_state_e       state;
        logic [ONES_W-1:0] ones;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] regad;
        logic              rd;
        logic              oe;
        logic              dout;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [HDR_W-1:0]  hdr_next;
    logic [OP_W-1:0]   op_dec;
    logic [ADDR_W-1:0] pa_dec;
    logic [ADDR_W-1:0] ra_dec;

    always_comb begin
        fsm_d    = fsm_q;
        wr_en    = 1'b0;
        hdr_next = {fsm_q.hdr[HDR_W-2:0], mdio_i};
        op_dec   = hdr_next[HDR_W-1 -: OP_W];
        pa_dec   = hdr_next[2*ADDR_W-1 -: ADDR_W];
        ra_dec   = hdr_next[ADDR_W-1:0];
        wr_data  = {fsm_q.sh[DATA_W-2:0], mdio_i};
        case (fsm_q.state)
            ST_HUNT: begin
                if (mdio_i) begin
                    if (fsm_q.ones != ONES_W'(PRE_LEN)) fsm_d.ones = fsm_q.ones + 1'b1;
                end else begin
                    if (sup_en || fsm_q.ones == ONES_W'(PRE_LEN)) fsm_d.state = ST_SFD;
                    fsm_d.ones = '0;
                end
            end
            ST_SFD: begin
                fsm_d.cnt   = '0;
                fsm_d.state = mdio_i ? ST_HDR : ST_HUNT;
            end
            ST_HDR: begin
                fsm_d.hdr = hdr_next;
                if (fsm_q.cnt == CNT_W'(HDR_W - 1)) begin
                    fsm_d.cnt   = '0;
                    fsm_d.regad = ra_dec;
                    fsm_d.rd    = (op_dec == OP_RD);
                    if ((op_dec == OP_RD || op_dec == OP_WR) && pa_dec == phy_addr)
                        fsm_d.state = ST_TA;
                    else
                        fsm_d.state = ST_SKIP;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_TA: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.cnt = CNT_W'(1);
                    if (fsm_q.rd) begin
                        fsm_d.oe   = 1'b1;
                        fsm_d.dout = 1'b0;
                        fsm_d.sh   = rdata;
                    end
                end else begin
                    fsm_d.cnt   = '0;
                    fsm_d.state = ST_DATA;
                    if (fsm_q.rd) begin
                        fsm_d.dout = fsm_q.sh[DATA_W-1];
                        fsm_d.sh   = {fsm_q.sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
            ST_DATA: begin
                if (fsm_q.rd) begin
                    if (fsm_q.cnt == CNT_W'(DATA_W - 1)) begin
                        fsm_d.oe    = 1'b0;
                        fsm_d.dout  = 1'b0;
                        fsm_d.state = ST_HUNT;
                        fsm_d.cnt   = '0;
                    end else begin
                        fsm_d.dout = fsm_q.sh[DATA_W-1];
                        fsm_d.sh   = {fsm_q.sh[DATA_W-2:0], 1'b0};
                        fsm_d.cnt  = fsm_q.cnt + 1'b1;
                    end
                end else begin
                    fsm_d.sh = wr_data;
                    if (fsm_q.cnt == CNT_W'(DATA_W - 1)) begin
                        wr_en       = 1'b1;
                        fsm_d.state = ST_HUNT;
                        fsm_d.cnt   = '0;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_SKIP: begin
                if (fsm_q.cnt == CNT_W'(SKIP_LEN - 1)) begin
                    fsm_d.state = ST_HUNT;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: fsm_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= ST_HUNT;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign reg_addr = fsm_q.regad;
    assign mdio_o   = fsm_q.dout;
    assign mdio_oe  = fsm_q.oe;

    // R11: drive only inside the answer phase of a read
    a_r11_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (fsm_q.rd && (fsm_q.state == ST_TA || fsm_q.state == ST_DATA)));

    // R6: first driven bit of a read is the turnaround zero
    a_r6_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R6: release coincides with the return to hunting
    a_r6_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> fsm_q.state == ST_HUNT);

    // R4: counted-out frames stay silent
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_SKIP) |-> !mdio_oe);
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs #(
    parameter int              DATA_W     = 16,
    parameter int              ADDR_W     = 5,
    parameter int              ADDR_CTRL  = 0,
    parameter int              ADDR_STAT  = 1,
    parameter int              ADDR_EXT   = 16,
    parameter int              ADDR_SCR   = 17,
    parameter logic [DATA_W-1:0] CTRL_RST   = 16'h1000,
    parameter logic [DATA_W-1:0] STAT_FIXED = 16'h7809,
    parameter int              SUP_BIT    = 6,
    parameter int              OVR_BIT    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              sup_en
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] scr;
        logic              sup;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  is_ctrl, is_stat, is_ext, is_scr, is_impl;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        is_ctrl = (addr == ADDR_W'(ADDR_CTRL));
        is_stat = (addr == ADDR_W'(ADDR_STAT));
        is_ext  = (addr == ADDR_W'(ADDR_EXT));
        is_scr  = (addr == ADDR_W'(ADDR_SCR));
        is_impl = is_ctrl || is_stat || is_ext || is_scr;

        stat_word          = STAT_FIXED;
        stat_word[SUP_BIT] = regs_q.sup;

        regs_d = regs_q;
        if (wr_en) begin
            if (is_ctrl) regs_d.ctrl = wr_data;
            if (is_ext)  regs_d.ext  = wr_data;
            if (is_scr)  regs_d.scr  = wr_data;
            if (is_stat && regs_q.ext[OVR_BIT]) regs_d.sup = wr_data[SUP_BIT];
        end

        if (is_ctrl)      rdata = regs_q.ctrl;
        else if (is_stat) rdata = stat_word;
        else if (is_ext)  rdata = regs_q.ext;
        else if (is_scr)  rdata = regs_q.scr;
        else              rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.ctrl <= CTRL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sup_en = regs_q.sup;

    // R8: the skip enable can only turn on while the override is set
    a_r8_sup_needs_override: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.sup) |-> $past(regs_q.ext[OVR_BIT]));

    // R10: writes to unimplemented addresses leave every register unchanged
    a_r10_unimpl_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_impl) |=> $stable(regs_q));
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int PRE_LEN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rdata;
    logic              sup_en;

    mgmt_frame_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PRE_LEN(PRE_LEN)
    ) u_fsm (
        .clk     (mdc),
        .rst_n   (rst_n),
        .mdio_i  (mdio_i),
        .phy_addr(phy_addr),
        .sup_en  (sup_en),
        .rdata   (rdata),
        .reg_addr(reg_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mgmt_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (mdc),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rdata  (rdata),
        .sup_en (sup_en)
    );
endmodule

// File: tb/tb_mgmt_serial_slave.sv
module tb_mgmt_serial_slave;
    localparam logic [4:0] STRAP = 5'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdio_i = 1'b1;
    logic [4:0] phy_addr = STRAP;
    logic       mdio_o, mdio_oe;

    int checks = 0;
    int fails  = 0;
    logic any_oe;

    logic [15:0] m_ctrl = 16'h1000;
    logic [15:0] m_ext  = 16'h0000;
    logic [15:0] m_scr  = 16'h0000;
    logic        m_sup  = 1'b0;

    always #5 clk = ~clk;

    mgmt_serial_slave dut (
        .mdc     (clk),
        .rst_n   (rst_n),
        .phy_addr(phy_addr),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    function automatic logic [15:0] exp_rd(input logic [4:0] r);
        case (r)
            5'd0:    return m_ctrl;
            5'd1:    return 16'h7809 | {9'b0, m_sup, 6'b0};
            5'd16:   return m_ext;
            5'd17:   return m_scr;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_wr(input logic [4:0] r, input logic [15:0] d);
        case (r)
            5'd0:  m_ctrl = d;
            5'd1:  if (m_ext[15]) m_sup = d[6];
            5'd16: m_ext = d;
            5'd17: m_scr = d;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        if (mdio_oe) any_oe = 1'b1;
        mdio_i = b;
        @(posedge clk);
    endtask

    task automatic do_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] wd,
                            output logic [15:0] rd, output logic ta_ok, output logic rel);
        logic ta1_oe;
        any_oe = 1'b0;
        rd = '0; ta_ok = 1'b0; rel = 1'b1;
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        if (op == 2'b10) begin
            @(negedge clk); ta1_oe = mdio_oe; mdio_i = 1'b1; @(posedge clk);
            @(negedge clk);
            if (mdio_oe) any_oe = 1'b1;
            ta_ok = !ta1_oe && mdio_oe && !mdio_o;
            @(posedge clk);
            for (int i = 15; i >= 0; i--) begin
                @(negedge clk);
                if (mdio_oe) any_oe = 1'b1;
                rd[i] = mdio_o;
                @(posedge clk);
            end
            @(negedge clk); rel = !mdio_oe; @(posedge clk);
        end else begin
            send_bit(1'b1); send_bit(1'b0);
            for (int i = 15; i >= 0; i--) send_bit(wd[i]);
        end
    endtask

    task automatic wr_reg(input int pre, input logic [4:0] ra, input logic [15:0] d, input string req);
        logic [15:0] rd; logic ta_ok, rel;
        do_frame(pre, 2'b01, STRAP, ra, d, rd, ta_ok, rel);
        chk({req, " write frame no drive"}, {15'b0, any_oe}, 16'h0);
        model_wr(ra, d);
    endtask

    task automatic rd_reg(input int pre, input logic [4:0] ra, input string req);
        logic [15:0] rd; logic ta_ok, rel;
        do_frame(pre, 2'b10, STRAP, ra, 16'h0, rd, ta_ok, rel);
        chk({req, " read data"}, rd, exp_rd(ra));
        chk({req, " R6 R11 turnaround"}, {15'b0, ta_ok}, 16'h1);
        chk({req, " R6 release"}, {15'b0, rel}, 16'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd; logic ta_ok, rel;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset enable", {15'b0, mdio_oe}, 16'h0);
        @(posedge clk);
        rd_reg(32, 5'd0, "R1 R3 ctrl");
        rd_reg(32, 5'd1, "R1 status");
        rd_reg(32, 5'd16, "R1 ext");
        rd_reg(32, 5'd17, "R1 scratch");

        // R5: device address sweep
        for (int a = 0; a < 32; a++) begin
            do_frame(32, 2'b10, 5'(a), 5'd1, 16'h0, rd, ta_ok, rel);
            if (5'(a) == STRAP) chk("R5 match read", rd, exp_rd(5'd1));
            else chk("R5 mismatch no drive", {15'b0, any_oe}, 16'h0);
        end
        wr_reg(32, 5'd17, 16'h1234, "R5");
        do_frame(32, 2'b01, STRAP ^ 5'h01, 5'd17, 16'hBEEF, rd, ta_ok, rel);
        rd_reg(32, 5'd17, "R5 mismatch write ignored");

        // R7: walking ones through scratch, then other writable words
        for (int b = 0; b < 16; b++) begin
            wr_reg(32, 5'd17, 16'(1) << b, "R7");
            rd_reg(32, 5'd17, "R7 scratch walk");
        end
        wr_reg(32, 5'd0, 16'hA5C3, "R7");
        rd_reg(32, 5'd0, "R7 ctrl");
        wr_reg(32, 5'd16, 16'h1234, "R7");
        rd_reg(32, 5'd16, "R7 ext");

        // R8: status bit change refused without override
        wr_reg(32, 5'd1, 16'hFFFF, "R8");
        rd_reg(32, 5'd1, "R8 status no override");

        // R10: unimplemented writes discarded, full address sweep
        wr_reg(32, 5'd5, 16'hFFFF, "R10");
        wr_reg(32, 5'd31, 16'hFFFF, "R10");
        for (int r = 0; r < 32; r++) rd_reg(32, 5'(r), "R10 sweep");

        // R4: invalid opcodes
        do_frame(32, 2'b00, STRAP, 5'd17, 16'h0000, rd, ta_ok, rel);
        chk("R4 op00 no drive", {15'b0, any_oe}, 16'h0);
        rd_reg(32, 5'd17, "R4 op00 no write");
        do_frame(32, 2'b11, STRAP, 5'd17, 16'h0000, rd, ta_ok, rel);
        chk("R4 op11 no drive", {15'b0, any_oe}, 16'h0);
        rd_reg(32, 5'd17, "R4 op11 no write");

        // R2: 31 ones are not a preamble
        send_bit(1'b0);
        do_frame(31, 2'b01, STRAP, 5'd17, 16'h0F0F, rd, ta_ok, rel);
        send_bit(1'b0);
        do_frame(31, 2'b10, STRAP, 5'd17, 16'h0, rd, ta_ok, rel);
        chk("R2 short preamble no drive", {15'b0, any_oe}, 16'h0);
        rd_reg(32, 5'd17, "R2 short preamble no write");

        // R8 R9: override, enable skipping, frames without preamble
        wr_reg(32, 5'd16, 16'h8000, "R8");
        wr_reg(32, 5'd1, 16'h0040, "R8");
        rd_reg(32, 5'd1, "R8 status enabled");
        wr_reg(0, 5'd17, 16'h5A5A, "R9");
        rd_reg(0, 5'd17, "R9 no preamble read");
        rd_reg(0, 5'd1, "R9 status");
        wr_reg(0, 5'd1, 16'h0000, "R8");
        rd_reg(32, 5'd1, "R8 status disabled");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule